// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM

This block produces one pulse-width-modulated output whose high time is set with a 10-bit value, while its period is set by an 8-bit timer. The timer is stretched with two fractional bits taken from the prescale counter. This gives the duty value four times the resolution of the period. Software writes the duty value in two pieces, an 8-bit upper part and a 2-bit lower part. The block copies the value into a hidden shadow register only when a period begins, so a write made mid-period never produces a runt or a stretched pulse.

The timer advances once every 4×P input clocks, where P is the selected prescale factor (1, 4 or 16). The 10-bit extended count therefore advances once every P clocks. The output goes high when a period starts. It goes low when the extended count reaches the shadowed duty value. When the count equals the period register at the end of a timer step, a new period starts: the counters clear, the shadow reloads, and the output is set again. The upper 8 bits of the shadow can be read on a dedicated output but cannot be written.

Top module: `fine_pwm`

## Requirements
- R1: After reset the output is low, the shadow upper part reads 0, both duty parts are 0, the block is disabled, and the period register holds 0xFF. A block enabled with duty upper part 1 and prescale 1 is therefore high for 4 clocks out of 1024.
- R2: A write to address 0 sets the control fields: bit 0 enable, bits 2:1 prescale select, bits 5:4 duty lower part. A write to address 1 sets the duty upper part, and a write to address 2 sets the period register.
- R3: When enable is written from 0 to 1 at clock edge E1, a period starts at edge E2 (the next edge). The output goes high at E2 for a nonzero duty. The output rises only at a period start.
- R4: For a duty value D below 4×(period+1), the output is high for exactly D×P clocks of each period.
- R5: A period lasts exactly 4×(period+1)×P clocks, measured between consecutive rising edges of the output.
- R6: For a duty value of at least 4×(period+1), no match occurs and the output stays high for the whole period.
- R7: A duty value of 0 keeps the output low for the whole period.
- R8: The shadow loads the duty value only at a period start. A duty write made mid-period has no effect on the current period's high time or on the shadow upper part. It takes effect from the next period.
- R9: Writing enable to 0 drives the output low by the second clock edge after the write. The output stays low, and the shadow upper part keeps its value.
- R10: Prescale select 0 gives P=1, select 1 gives P=4, and selects 2 and 3 both give P=16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address (0 control, 1 duty upper, 2 period) |
| wrData | input | 8 | Register write data |
| pwmOut | output | 1 | PWM output |
| shadowHi | output | 8 | Read-only upper 8 bits of the shadowed duty value |

## Verification
The bench keeps the default widths: an 8-bit timer, 2 fractional bits and three prescale levels. It sweeps small period values (0 to 3) over every duty value from 0 to a few steps past the period length. It does this for prescale factors 1 and 4, and for a reduced set at factor 16. This keeps each period short enough that zero duty, in-range duty, exact period length and overflowing duty can all be measured cycle by cycle at every prescale. Directed runs cover the reset period of 0xFF, the exact enable-to-output latency, a duty write made mid-period, and disabling a running output.

// File: rtl/fine_pwm_pkg.sv
package fine_pwm_pkg;

  // register addresses on the write port
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;

  // control register field positions
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PS_LSB  = 1;
  localparam int CTRL_DLO_LSB = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic halt;   // block disabled: clear counters, output low
    logic load;   // period start: clear counters, reload shadow, set output
    logic run;    // counting inside a period
  } pwmStrobe_t;

endpackage

// File: rtl/fine_pwm_ctrl.sv
module fine_pwm_ctrl
  import fine_pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  input  logic              atEnd,
  output pwmStrobe_t        ctl,
  output logic [SEL_W-1:0]  psSel,
  output logic [TMR_W-1:0]  dutyHi,
  output logic [FRAC_W-1:0] dutyLo,
  output logic [TMR_W-1:0]  period
);

  logic enable;
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      psSel  <= '0;
      dutyLo <= '0;
      dutyHi <= '0;
      period <= '1;
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_CTRL: begin
          enable <= wrData[CTRL_EN_BIT];
          psSel  <= wrData[CTRL_PS_LSB +: SEL_W];
          dutyLo <= wrData[CTRL_DLO_LSB +: FRAC_W];
        end
        ADDR_DUTY:   dutyHi <= wrData;
        ADDR_PERIOD: period <= wrData;
        default: ;
      endcase
    end
  end

  // a period starts on the first enabled cycle and at every timer wrap
  always_comb begin
    ctl.halt = !enable;
    ctl.load = enable && (!running || atEnd);
    ctl.run  = enable && running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        running <= 1'b0;
    else if (!enable) running <= 1'b0;
    else if (ctl.load) running <= 1'b1;
  end

endmodule

// File: rtl/fine_pwm_dp.sv
module fine_pwm_dp
  import fine_pwm_pkg::*;
#(
  parameter int TMR_W     = 8,
  parameter int FRAC_W    = 2,
  parameter int PS_STEP   = 2,
  parameter int PS_LEVELS = 3,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        ctl,
  input  logic [SEL_W-1:0]  psSel,
  input  logic [TMR_W-1:0]  dutyHi,
  input  logic [FRAC_W-1:0] dutyLo,
  input  logic [TMR_W-1:0]  period,
  output logic              atEnd,
  output logic              pwmOut,
  output logic [TMR_W-1:0]  shadowHi
);

  localparam int DIV_W = FRAC_W + PS_STEP * (PS_LEVELS - 1);
  localparam int EXT_W = TMR_W + FRAC_W;

  logic [TMR_W-1:0]  tmrQ, tmrNext;
  logic [DIV_W-1:0]  divQ, divNext, divLast;
  logic [EXT_W-1:0]  shadowQ, extNext, dutyNew;
  logic [FRAC_W-1:0] fracNext;
  logic [SEL_W-1:0]  selIdx;
  int unsigned       shiftAmt;
  logic              divWrap;

  // selects above the last level saturate to the largest factor
  always_comb begin
    selIdx   = (psSel > SEL_W'(PS_LEVELS - 1)) ? SEL_W'(PS_LEVELS - 1) : psSel;
    shiftAmt = int'(selIdx) * PS_STEP;
    divLast  = {DIV_W{1'b1}} >> (DIV_W - FRAC_W - shiftAmt);
  end

  always_comb begin
    divWrap  = (divQ >= divLast);
    divNext  = divWrap ? '0 : divQ + 1'b1;
    tmrNext  = divWrap ? tmrQ + 1'b1 : tmrQ;
    fracNext = FRAC_W'(divNext >> shiftAmt);
    extNext  = {tmrNext, fracNext};
    atEnd    = divWrap && (tmrQ == period);
    dutyNew  = {dutyHi, dutyLo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ    <= '0;
      divQ    <= '0;
      shadowQ <= '0;
      pwmOut  <= 1'b0;
    end else if (ctl.halt) begin
      tmrQ   <= '0;
      divQ   <= '0;
      pwmOut <= 1'b0;
    end else if (ctl.load) begin
      tmrQ    <= '0;
      divQ    <= '0;
      shadowQ <= dutyNew;
      pwmOut  <= (dutyNew != '0);
    end else if (ctl.run) begin
      tmrQ <= tmrNext;
      divQ <= divNext;
      if (extNext == shadowQ) pwmOut <= 1'b0;
    end
  end

  assign shadowHi = shadowQ[EXT_W-1:FRAC_W];

endmodule

// File: rtl/fine_pwm.sv
module fine_pwm
  import fine_pwm_pkg::*;
#(
  parameter int TMR_W     = 8,
  parameter int FRAC_W    = 2,
  parameter int PS_STEP   = 2,
  parameter int PS_LEVELS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [TMR_W-1:0] wrData,
  output logic             pwmOut,
  output logic [TMR_W-1:0] shadowHi
);

  localparam int SEL_W = $clog2(PS_LEVELS);

  pwmStrobe_t        ctl;
  logic              atEnd;
  logic [SEL_W-1:0]  psSel;
  logic [TMR_W-1:0]  dutyHi;
  logic [FRAC_W-1:0] dutyLo;
  logic [TMR_W-1:0]  period;

  fine_pwm_ctrl #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .atEnd(atEnd), .ctl(ctl), .psSel(psSel), .dutyHi(dutyHi),
    .dutyLo(dutyLo), .period(period)
  );

  fine_pwm_dp #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .PS_STEP(PS_STEP),
                .PS_LEVELS(PS_LEVELS), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .psSel(psSel), .dutyHi(dutyHi),
    .dutyLo(dutyLo), .period(period), .atEnd(atEnd), .pwmOut(pwmOut),
    .shadowHi(shadowHi)
  );

endmodule

// File: rtl/fine_pwm_chk.sv
module fine_pwm_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwmOut,
  input logic [TMR_W-1:0] shadowHi,
  input logic             loadStb,
  input logic             haltStb,
  input logic             dutyZero
);

  // R8: shadow changes only at a period start
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(shadowHi));

  // R3: output rises only as a period starts
  p_rise_at_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(loadStb));

  // R9: disabled block drives the output low
  p_off_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    haltStb |=> !pwmOut);

  // R7: zero duty starts the period low
  p_zero_duty_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && dutyZero) |=> !pwmOut);

  // R6: nonzero duty starts the period high
  p_start_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !dutyZero) |=> pwmOut);

endmodule

bind fine_pwm fine_pwm_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .shadowHi(shadowHi),
  .loadStb(ctl.load), .haltStb(ctl.halt), .dutyZero({dutyHi, dutyLo} == '0)
);

// File: tb/fine_pwm_test.sv
module fine_pwm_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut;
  logic [7:0] shadowHi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fine_pwm uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .shadowHi(shadowHi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int psFactor(input int ps);
    return (ps >= 2) ? 16 : ((ps == 1) ? 4 : 1);
  endfunction

  function automatic logic [7:0] ctrlWord(input int ps, input int lo, input bit en);
    return 8'((lo << 4) | (ps << 1) | int'(en));
  endfunction

  // configure, enable, and measure two full periods aligned to the start
  task automatic sweepOne(input int ps, input int pr, input int duty);
    int perTicks = 4 * (pr + 1);
    int p = psFactor(ps);
    int periodClk = perTicks * p;
    int highClk = ((duty < perTicks) ? duty : perTicks) * p;
    int highs = 0;
    int rises = 0;
    int firstRise = -1;
    int secondRise = -1;
    logic prev = 1'b0;
    wr(2'd0, 8'h00);
    @(negedge clk);
    wr(2'd2, 8'(pr));
    wr(2'd1, 8'(duty >> 2));
    wr(2'd0, ctrlWord(ps, duty & 3, 1'b1));
    for (int i = 0; i < 2 * periodClk; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
      if (pwmOut && !prev) begin
        rises++;
        if (firstRise < 0) firstRise = i;
        else if (secondRise < 0) secondRise = i;
      end
      prev = pwmOut;
    end
    if (duty == 0)
      chk($sformatf("R7 zero duty ps=%0d pr=%0d highs", ps, pr), highs, 0);
    else if (duty >= perTicks)
      chk($sformatf("R6 overflow duty ps=%0d pr=%0d d=%0d highs", ps, pr, duty), highs, 2 * periodClk);
    else begin
      chk($sformatf("R4 R10 high time ps=%0d pr=%0d d=%0d", ps, pr, duty), highs, 2 * highClk);
      chk($sformatf("R5 period ps=%0d pr=%0d d=%0d", ps, pr, duty), secondRise - firstRise, periodClk);
    end
  endtask

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset output", int'(pwmOut), 0);
    chk("R1 reset shadow", int'(shadowHi), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 output low while disabled", int'(pwmOut), 0);

    // R1 period 0xFF after reset, R3 enable latency
    wr(2'd1, 8'd1);
    wr(2'd0, ctrlWord(0, 0, 1'b1));
    chk("R3 output still low one edge after enable", int'(pwmOut), 0);
    highs = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (i == 0) chk("R3 output high at period start", int'(pwmOut), 1);
      if (pwmOut) highs++;
    end
    chk("R1 reset period 0xFF high count", highs, 4);
    chk("R2 shadow upper part loaded", int'(shadowHi), 1);

    // R9 disable a permanently high output
    wr(2'd0, 8'h00);
    @(negedge clk);
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd9);
    wr(2'd0, ctrlWord(0, 0, 1'b1));
    repeat (7) @(negedge clk);
    chk("R6 overflow output high mid-period", int'(pwmOut), 1);
    wr(2'd0, ctrlWord(0, 0, 1'b0));
    @(negedge clk);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
    chk("R9 output low after disable", highs, 0);
    chk("R9 shadow held after disable", int'(shadowHi), 9);

    // R8 mid-period duty write
    wr(2'd0, 8'h00);
    @(negedge clk);
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd1);
    wr(2'd0, ctrlWord(0, 2, 1'b1));   // duty 6
    highs = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
      if (i == 4) wrEn = 1'b0;
      if (i == 3) begin
        wrEn = 1'b1; wrAddr = 2'd1; wrData = 8'd2;   // new duty 10
      end
      if (i == 10) chk("R8 shadow unchanged mid-period", int'(shadowHi), 1);
    end
    chk("R8 current period keeps old duty", highs, 6);
    highs = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == 0) chk("R8 shadow updated at period start", int'(shadowHi), 2);
      if (pwmOut) highs++;
    end
    chk("R8 next period uses new duty", highs, 10);

    // near-exhaustive sweeps
    for (int ps = 0; ps < 2; ps++)
      for (int pr = 0; pr < 4; pr++)
        for (int d = 0; d <= 4 * pr + 5; d++)
          sweepOne(ps, pr, d);
    for (int pr = 0; pr < 2; pr++)
      for (int d = 0; d <= 4 * pr + 5; d++)
        sweepOne(2, pr, d);
    // R10 select 3 behaves as 16
    sweepOne(3, 1, 3);
    sweepOne(3, 0, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule